// File: doc/BRIEF.md
# Bit-Alias Bus Bridge

This bridge sits between a processor-side request port and a byte-addressable memory port. It recognises accesses that fall inside one of two 32 MiB alias windows and turns each of them into a single-bit operation on a smaller target region. Every aligned word of an alias window stands for one bit of the target. A read through the window returns that bit as 0 or 1. A write through the window performs a read-modify-write of the containing byte, halfword or word. The sequence changes only the selected bit and writes the whole unit back at the size of the original access. Any access outside both windows is forwarded to the memory port unchanged.

Both ports use a hold-until-acknowledged handshake. The requester keeps `s_req` and its fields stable until `s_ready` pulses for one cycle. The bridge keeps `m_req` and its fields stable until the memory pulses `m_ack`. For reads, `m_rdata` is valid in the `m_ack` cycle. Data on both ports is right-justified and little-endian: a halfword or word occupies the low bits of the bus, and bit indices count from its least significant bit.

Top module: `bitalias_bridge`

## Requirements
- R1: An address outside both alias windows (alias window 0 spans 0x2200_0000 to 0x23FF_FFFF, alias window 1 spans 0x4200_0000 to 0x43FF_FFFF) is forwarded to the memory port with the same address, direction, size and write data. The memory's read data and acknowledge are returned as `s_rdata` and `s_ready`.
- R2: For an alias address A in window w, the target byte address is T = base_w OR ((A AND 0x01FF_FFFF) >> 5). base_w is 0x2000_0000 for window 0 and 0x4000_0000 for window 1. T is then aligned down to 2 bytes for a halfword access (size code 1) and to 4 bytes for a word access (size code 2). A byte access uses size code 0.
- R3: The bit index within the target unit is A[4:2] for a byte, A[5:2] for a halfword and A[6:2] for a word. Bit 0 is the least significant bit of the little-endian unit.
- R4: An alias read issues one memory read of the target unit at the access size. It returns `s_rdata` = 1 when the selected bit is set and 0 otherwise, with bits 31:1 always zero.
- R5: An alias write issues a memory read of the target unit, then a memory write to the same address with the same size. No other memory transaction comes between them.
- R6: In the write-back of an alias write, the selected bit equals bit 0 of `s_wdata`: 1 sets the bit and 0 clears it. Every other bit of the unit keeps the value just read, and the upper bits of `s_wdata` have no effect.
- R7: `s_ready` stays low through both phases of an alias write and pulses only together with the acknowledge of the write-back. The bridge accepts no new request before that pulse.
- R8: While reset is asserted, and in the first cycle after reset is released, `m_req` and `s_ready` are low.
- R9: The two windows are independent. A write through window 1 changes only memory based at 0x4000_0000, and the first word past window 0 (0x2400_0000) is not translated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_req | input | 1 | Request from the processor side, held until `s_ready` |
| s_we | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| s_addr | input | 32 | Byte address of the request |
| s_wdata | input | 32 | Write data, right-justified |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result, valid with `s_ready` |
| m_req | output | 1 | Request to memory, held until `m_ack` |
| m_we | output | 1 | 1 = write, 0 = read |
| m_size | output | 2 | Size code of the memory access |
| m_addr | output | 32 | Byte address of the memory access |
| m_wdata | output | 32 | Write data to memory, right-justified |
| m_ack | input | 1 | One-cycle acknowledge from memory |
| m_rdata | input | 32 | Read data from memory, valid with `m_ack` |

## Verification
The hardest behaviour to observe from the ports is the hidden read-modify-write. One slave write becomes two memory transactions, and a wrong address, a wrong size or a disturbed neighbouring bit shows up only later, if at all. The stimulus first places known patterns in the target memory through the pass-through path. It then writes single bits through each window at every access size, using bits at the top of a byte, halfword or word, and write data whose upper bits contradict bit 0. It logs every memory transaction and reads the whole word back through the pass-through path to expose any collateral change. The last alias word of a window and the first address past it are driven on purpose, so that the window edge and the largest offset are both exercised.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int BB_AW = 32;
  localparam int BB_DW = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Bits of the unit that an access of this size covers.
  function automatic logic [BB_DW-1:0] unit_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: unit_mask = 32'h0000_00FF;
      SZ_HALF: unit_mask = 32'h0000_FFFF;
      default: unit_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Bit position selected by an alias address for a given size.
  function automatic logic [4:0] bit_sel(input logic [BB_AW-1:0] a, input logic [1:0] sz);
    logic [4:0] raw;
    raw = a[6:2];
    case (sz)
      SZ_BYTE: bit_sel = {2'b00, raw[2:0]};
      SZ_HALF: bit_sel = {1'b0, raw[3:0]};
      default: bit_sel = raw;
    endcase
  endfunction

  // Align a byte address down to the natural boundary of the size.
  function automatic logic [BB_AW-1:0] align_down(input logic [BB_AW-1:0] a, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: align_down = a;
      SZ_HALF: align_down = {a[BB_AW-1:1], 1'b0};
      default: align_down = {a[BB_AW-1:2], 2'b00};
    endcase
  endfunction

  // Target byte address for an alias address: offset inside the window
  // divided by 32 (one word per bit), ORed onto the region base.
  function automatic logic [BB_AW-1:0] alias_target(input logic [BB_AW-1:0] base,
                                                    input logic [BB_AW-1:0] a,
                                                    input int unsigned     win_bits);
    logic [BB_AW-1:0] off_mask;
    off_mask     = (32'h1 << win_bits) - 32'h1;
    alias_target = base | ((a & off_mask) >> 5);
  endfunction

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
  import bb_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned WIN_BITS = 25,
  parameter logic [NUM_WIN-1:0][BB_AW-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][BB_AW-1:0] TGT_BASE   = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [BB_AW-1:0] addr,
  input  logic [1:0]       size,
  output logic             hit,
  output logic [BB_AW-1:0] tgt_addr,
  output logic [4:0]       bit_idx
);

  localparam int unsigned TAG_LO = WIN_BITS;

  logic [NUM_WIN-1:0]            hit_vec;
  logic [NUM_WIN-1:0][BB_AW-1:0] tgt_vec;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit_vec[w] = (addr[BB_AW-1:TAG_LO] == ALIAS_BASE[w][BB_AW-1:TAG_LO]);
    assign tgt_vec[w] = hit_vec[w]
                      ? align_down(alias_target(TGT_BASE[w], addr, WIN_BITS), size)
                      : '0;
  end

  always_comb begin
    tgt_addr = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      tgt_addr = tgt_addr | tgt_vec[w];
    end
  end

  assign hit     = |hit_vec;
  assign bit_idx = bit_sel(addr, size);

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [BB_DW-1:0] unit_raw,
  input  logic [1:0]       size,
  input  logic [4:0]       bit_idx,
  input  logic             set_val,
  output logic             bit_val,
  output logic [BB_DW-1:0] unit_clean,
  output logic [BB_DW-1:0] merged
);

  logic [BB_DW-1:0] sel;

  assign unit_clean = unit_raw & unit_mask(size);
  assign sel        = {{(BB_DW-1){1'b0}}, 1'b1} << bit_idx;
  assign bit_val    = |(unit_clean & sel);
  assign merged     = set_val ? (unit_clean | sel) : (unit_clean & ~sel);

endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq
  import bb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             s_req,
  input  logic             s_we,
  input  logic [1:0]       s_size,
  input  logic [BB_AW-1:0] s_addr,
  input  logic [BB_DW-1:0] s_wdata,
  input  logic             dec_hit,
  input  logic [BB_AW-1:0] dec_tgt,
  input  logic [4:0]       dec_idx,
  input  logic             m_ack,
  input  logic [BB_DW-1:0] m_rdata,
  input  logic             mrg_bit,
  input  logic [BB_DW-1:0] mrg_clean,
  input  logic [BB_DW-1:0] mrg_word,
  output logic             s_ready,
  output logic [BB_DW-1:0] s_rdata,
  output logic             m_req,
  output logic             m_we,
  output logic [1:0]       m_size,
  output logic [BB_AW-1:0] m_addr,
  output logic [BB_DW-1:0] m_wdata,
  output logic [1:0]       size_q,
  output logic [4:0]       idx_q,
  output logic             set_q,
  output logic             pass_active,
  output logic             fetch_done_rd,
  output logic             fetch_done_wr,
  output logic             store_phase,
  output logic [BB_DW-1:0] unit_q
);

  typedef enum logic [1:0] {ST_IDLE, ST_PASS, ST_FETCH, ST_STORE} seq_state_e;

  seq_state_e       state;
  logic             we_q;
  logic [BB_AW-1:0] addr_q;
  logic [BB_AW-1:0] tgt_q;
  logic [BB_DW-1:0] wdata_q;
  logic [BB_DW-1:0] wb_q;

  assign pass_active   = (state == ST_PASS);
  assign store_phase   = (state == ST_STORE);
  assign fetch_done_rd = (state == ST_FETCH) && m_ack && !we_q;
  assign fetch_done_wr = (state == ST_FETCH) && m_ack && we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      tgt_q   <= '0;
      wdata_q <= '0;
      wb_q    <= '0;
      unit_q  <= '0;
      size_q  <= SZ_BYTE;
      idx_q   <= '0;
      set_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (s_req) begin
            we_q    <= s_we;
            addr_q  <= s_addr;
            wdata_q <= s_wdata;
            size_q  <= s_size;
            tgt_q   <= dec_tgt;
            idx_q   <= dec_idx;
            set_q   <= s_wdata[0];
            state   <= dec_hit ? ST_FETCH : ST_PASS;
          end
        end
        ST_PASS: begin
          if (m_ack) state <= ST_IDLE;
        end
        ST_FETCH: begin
          if (m_ack) begin
            if (we_q) begin
              unit_q <= mrg_clean;
              wb_q   <= mrg_word;
              state  <= ST_STORE;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        ST_STORE: begin
          if (m_ack) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    m_req   = (state != ST_IDLE);
    m_size  = size_q;
    m_addr  = pass_active ? addr_q  : tgt_q;
    m_we    = pass_active ? we_q    : store_phase;
    m_wdata = pass_active ? wdata_q : wb_q;
    s_ready = m_ack && (pass_active || store_phase || (state == ST_FETCH && !we_q));
    if (pass_active)                s_rdata = m_rdata;
    else if (state == ST_FETCH)     s_rdata = {{(BB_DW-1){1'b0}}, mrg_bit};
    else                            s_rdata = '0;
  end

endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
  import bb_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned WIN_BITS = 25,
  parameter logic [NUM_WIN-1:0][31:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][31:0] TGT_BASE   = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        s_req,
  input  logic        s_we,
  input  logic [1:0]  s_size,
  input  logic [31:0] s_addr,
  input  logic [31:0] s_wdata,
  output logic        s_ready,
  output logic [31:0] s_rdata,
  output logic        m_req,
  output logic        m_we,
  output logic [1:0]  m_size,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  input  logic        m_ack,
  input  logic [31:0] m_rdata
);

  logic             dec_hit;
  logic [BB_AW-1:0] dec_tgt;
  logic [4:0]       dec_idx;
  logic [1:0]       size_q;
  logic [4:0]       idx_q;
  logic             set_q;
  logic             mrg_bit;
  logic [BB_DW-1:0] mrg_clean;
  logic [BB_DW-1:0] mrg_word;
  logic             pass_active;
  logic             fetch_done_rd;
  logic             fetch_done_wr;
  logic             store_phase;
  logic [BB_DW-1:0] unit_q;

  bb_window_decode #(
    .NUM_WIN    (NUM_WIN),
    .WIN_BITS   (WIN_BITS),
    .ALIAS_BASE (ALIAS_BASE),
    .TGT_BASE   (TGT_BASE)
  ) u_dec (
    .addr     (s_addr),
    .size     (s_size),
    .hit      (dec_hit),
    .tgt_addr (dec_tgt),
    .bit_idx  (dec_idx)
  );

  bb_bit_merge u_mrg (
    .unit_raw   (m_rdata),
    .size       (size_q),
    .bit_idx    (idx_q),
    .set_val    (set_q),
    .bit_val    (mrg_bit),
    .unit_clean (mrg_clean),
    .merged     (mrg_word)
  );

  bb_rmw_seq u_seq (
    .clk           (clk),
    .rst           (rst),
    .s_req         (s_req),
    .s_we          (s_we),
    .s_size        (s_size),
    .s_addr        (s_addr),
    .s_wdata       (s_wdata),
    .dec_hit       (dec_hit),
    .dec_tgt       (dec_tgt),
    .dec_idx       (dec_idx),
    .m_ack         (m_ack),
    .m_rdata       (m_rdata),
    .mrg_bit       (mrg_bit),
    .mrg_clean     (mrg_clean),
    .mrg_word      (mrg_word),
    .s_ready       (s_ready),
    .s_rdata       (s_rdata),
    .m_req         (m_req),
    .m_we          (m_we),
    .m_size        (m_size),
    .m_addr        (m_addr),
    .m_wdata       (m_wdata),
    .size_q        (size_q),
    .idx_q         (idx_q),
    .set_q         (set_q),
    .pass_active   (pass_active),
    .fetch_done_rd (fetch_done_rd),
    .fetch_done_wr (fetch_done_wr),
    .store_phase   (store_phase),
    .unit_q        (unit_q)
  );

endmodule

// File: rtl/bitalias_bridge_chk.sv
module bitalias_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        s_we,
  input logic [31:0] s_addr,
  input logic        s_ready,
  input logic [31:0] s_rdata,
  input logic        m_req,
  input logic        m_we,
  input logic [1:0]  m_size,
  input logic [31:0] m_addr,
  input logic [31:0] m_wdata,
  input logic        m_ack,
  input logic        pass_active,
  input logic        fetch_done_rd,
  input logic        fetch_done_wr,
  input logic        store_phase,
  input logic [31:0] unit_q
);

  // R8
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!m_req && !s_ready));

  // R7
  ready_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> m_ack);

  // R5
  wb_same_unit_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_done_wr |=> (m_req && m_we && m_addr == $past(m_addr) && m_size == $past(m_size)));

  // R6
  single_bit_diff_chk: assert property (@(posedge clk) disable iff (rst)
    store_phase |-> ($countones(m_wdata ^ unit_q) <= 1));

  // R4
  bit_only_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_done_rd |-> (s_ready && s_rdata[31:1] == 31'd0));

  // R1
  pass_exact_chk: assert property (@(posedge clk) disable iff (rst)
    pass_active |-> (m_addr == s_addr && m_we == s_we));

endmodule

bind bitalias_bridge bitalias_bridge_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .s_we          (s_we),
  .s_addr        (s_addr),
  .s_ready       (s_ready),
  .s_rdata       (s_rdata),
  .m_req         (m_req),
  .m_we          (m_we),
  .m_size        (m_size),
  .m_addr        (m_addr),
  .m_wdata       (m_wdata),
  .m_ack         (m_ack),
  .pass_active   (pass_active),
  .fetch_done_rd (fetch_done_rd),
  .fetch_done_wr (fetch_done_wr),
  .store_phase   (store_phase),
  .unit_q        (unit_q)
);

// File: tb/sim_bitalias_bridge.sv
`timescale 1ns/1ps
module sim_bitalias_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_req = 1'b0;
  logic        s_we = 1'b0;
  logic [1:0]  s_size = 2'd0;
  logic [31:0] s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic        s_ready;
  logic [31:0] s_rdata;
  logic        m_req;
  logic        m_we;
  logic [1:0]  m_size;
  logic [31:0] m_addr;
  logic [31:0] m_wdata;
  logic        m_ack = 1'b0;
  logic [31:0] m_rdata = '0;

  always #2 clk = ~clk;

  bitalias_bridge u0 (
    .clk(clk), .rst(rst), .s_req(s_req), .s_we(s_we), .s_size(s_size),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
    .m_req(m_req), .m_we(m_we), .m_size(m_size), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Memory model: 512 bytes, indexed by address bit 30 and the low byte.
  logic [7:0] mem [512];
  function automatic int mi(input logic [31:0] a);
    return {a[30], a[7:0]};
  endfunction
  function automatic logic [31:0] mem_rd(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (k < (1 << sz)) v[8*k +: 8] = mem[mi(a + k)];
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) m_ack <= 1'b0;
    else if (m_req && !m_ack) begin
      m_ack <= 1'b1;
      if (m_we) begin
        for (int k = 0; k < 4; k++)
          if (k < (1 << m_size)) mem[mi(m_addr + k)] <= m_wdata[8*k +: 8];
      end else m_rdata <= mem_rd(m_addr, m_size);
    end else m_ack <= 1'b0;
  end

  // Log of memory transactions, sampled away from the edge.
  bit          op_we   [256];
  logic [31:0] op_addr [256];
  logic [1:0]  op_size [256];
  logic [31:0] op_data [256];
  int          n_ops = 0;
  always @(negedge clk) begin
    if (!rst && m_req && m_ack && n_ops < 256) begin
      op_we[n_ops]   = m_we;
      op_addr[n_ops] = m_addr;
      op_size[n_ops] = m_size;
      op_data[n_ops] = m_wdata;
      n_ops++;
    end
  end

  // Scoreboard.
  typedef struct { bit chk_data; logic [31:0] exp; bit exp_wb; } sb_item_t;
  sb_item_t sb_q[$];
  string    tag_q[$];

  always @(negedge clk) begin
    if (!rst && s_ready) begin
      if (sb_q.size() == 0) check(1'b0, "R7 unexpected s_ready", 32'd1, 32'd0);
      else begin
        sb_item_t it;
        string t;
        it = sb_q.pop_front();
        t  = tag_q.pop_front();
        if (it.chk_data) check(s_rdata == it.exp, t, s_rdata, it.exp);
        // R7: an alias write completes only with the write-back acknowledge
        if (it.exp_wb) check(m_we == 1'b1, "R7 ready before write-back", {31'd0, m_we}, 32'd1);
      end
    end
  end

  task automatic xfer(input bit we, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input bit chk, input logic [31:0] exp,
                      input bit wb, input string tag);
    sb_item_t it;
    it.chk_data = chk; it.exp = exp; it.exp_wb = wb;
    sb_q.push_back(it);
    tag_q.push_back(tag);
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_addr = a; s_size = sz; s_wdata = wd;
    do @(negedge clk); while (!s_ready);
    @(posedge clk);
    #1 s_req = 1'b0;
  endtask

  // Independent restatement of the alias mapping.
  function automatic logic [31:0] ref_tgt(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] base, t;
    int nb;
    base = (a >= 32'h4200_0000) ? 32'h4000_0000 : 32'h2000_0000;
    t    = base + (a - (base + 32'h0200_0000)) / 32;
    nb   = 1 << sz;
    return t - (t % nb);
  endfunction

  task automatic check_rmw(input int first, input logic [31:0] a, input logic [1:0] sz,
                           input logic [31:0] wb_exp, input string tag);
    logic [31:0] t;
    t = ref_tgt(a, sz);
    check(n_ops == first + 2, {tag, " op count"}, n_ops - first, 2);
    check(!op_we[first] && op_addr[first] == t && op_size[first] == sz,
          {tag, " fetch"}, op_addr[first], t);
    check(op_we[first+1] && op_addr[first+1] == t && op_size[first+1] == sz,
          {tag, " store"}, op_addr[first+1], t);
    check(op_data[first+1] == wb_exp, {tag, " store data"}, op_data[first+1], wb_exp);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  end

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    int p;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R8
    check(!m_req && !s_ready, "R8 reset state", {30'd0, m_req, s_ready}, 32'd0);

    // R1: pass-through write and read back
    xfer(1, 32'h2000_0010, 2'd2, 32'hA5A5_0F0F, 0, 0, 0, "R1 pass write");
    xfer(0, 32'h2000_0010, 2'd2, 0, 1, 32'hA5A5_0F0F, 0, "R1 pass read");

    // R4 R3: word alias reads of bits 0, 4, 31 of word 0x2000_0010
    xfer(0, 32'h2200_0200, 2'd2, 0, 1, 32'd1, 0, "R4 word bit0");
    xfer(0, 32'h2200_0210, 2'd2, 0, 1, 32'd0, 0, "R4 word bit4");
    p = n_ops;
    xfer(0, 32'h2200_027C, 2'd2, 0, 1, 32'd1, 0, "R3 word bit31");
    check(n_ops == p + 1 && !op_we[p], "R4 single read", n_ops - p, 1);

    // R5 R6: word alias write sets bit 4
    p = n_ops;
    xfer(1, 32'h2200_0210, 2'd2, 32'd1, 0, 0, 1, "R5 word set");
    check_rmw(p, 32'h2200_0210, 2'd2, 32'hA5A5_0F1F, "R5 word set");

    // R2 R6: byte alias write clears bit 3 of byte 0x2000_0011; upper wdata bits set
    p = n_ops;
    xfer(1, 32'h2200_022C, 2'd0, 32'hFFFF_FFFE, 0, 0, 1, "R6 byte clear");
    check_rmw(p, 32'h2200_022C, 2'd0, 32'h0000_0007, "R2 byte clear");
    xfer(0, 32'h2000_0010, 2'd2, 0, 1, 32'hA5A5_071F, 0, "R6 byte neighbours");

    // R2 R3: halfword alias write clears bit 15 of halfword 0x2000_0012
    p = n_ops;
    xfer(1, 32'h2200_027C, 2'd1, 32'd0, 0, 0, 1, "R6 half clear");
    check_rmw(p, 32'h2200_027C, 2'd1, 32'h0000_25A5, "R2 half clear");
    xfer(0, 32'h2000_0010, 2'd2, 0, 1, 32'h25A5_071F, 0, "R6 half neighbours");
    xfer(0, 32'h2200_027C, 2'd1, 0, 1, 32'd0, 0, "R3 half read bit15");
    xfer(0, 32'h2200_022C, 2'd0, 0, 1, 32'd0, 0, "R3 byte read bit3");
    xfer(0, 32'h2200_0228, 2'd0, 0, 1, 32'd1, 0, "R3 byte read bit2");

    // R9: second window
    xfer(1, 32'h4000_0020, 2'd2, 32'h0000_0001, 0, 0, 0, "R9 pass write");
    p = n_ops;
    xfer(1, 32'h4200_047C, 2'd2, 32'h0000_0001, 0, 0, 1, "R9 win1 set");
    check_rmw(p, 32'h4200_047C, 2'd2, 32'h8000_0001, "R9 win1 set");
    xfer(0, 32'h4000_0020, 2'd2, 0, 1, 32'h8000_0001, 0, "R9 win1 readback");
    xfer(0, 32'h2000_0020, 2'd2, 0, 1, 32'h0000_0000, 0, "R9 win0 untouched");

    // R9 R1: first address past window 0 is forwarded untranslated
    p = n_ops;
    xfer(1, 32'h2400_0000, 2'd2, 32'h1122_3344, 0, 0, 0, "R1 past window");
    check(n_ops == p + 1 && op_addr[p] == 32'h2400_0000, "R1 past window addr", op_addr[p], 32'h2400_0000);
    xfer(0, 32'h2000_0000, 2'd2, 0, 1, 32'h1122_3344, 0, "R9 past window data");

    // R2: last alias word of window 0 maps to the top word of the region
    p = n_ops;
    xfer(0, 32'h23FF_FFFC, 2'd2, 0, 1, 32'd0, 0, "R4 last alias word");
    check(op_addr[p] == ref_tgt(32'h23FF_FFFC, 2'd2) && op_addr[p] == 32'h200F_FFFC,
          "R2 last alias addr", op_addr[p], 32'h200F_FFFC);

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
    finish_up();
  end

endmodule